// File: doc/BRIEF.md
# Selectable-Timeout System Watchdog

This block is a system watchdog on a small I/O register bus. Software writes a configuration register to pick one of eight timeout limits and to turn the watchdog on. After that, the counter steps once on each pulse of an external prescaled time base, normally a 1 ms tick. Software has to touch a dedicated keep-alive address before the count reaches the selected limit. A read or a write of that address restarts the count from zero.

If the count reaches the limit first, the block raises a reset request toward the board reset logic. A build parameter selects how the request behaves. It is either a single-cycle pulse for each expiry, or a level that stays high until the block itself is reset.

The eight limits are computed rather than stored. Limit k is `LIMIT_BASE << ((k*TOP_EXP)/7)` ticks. With the default values and a 1 ms tick, the limits run from 2 ms to about 65.5 s.

Top module: `watchdog_core`

## Requirements
- R1: Select code k (0 to 7) sets a limit of `LIMIT_BASE << ((k*TOP_EXP)/7)` ticks. With the defaults this gives 2, 8, 32, 128, 512, 2048, 8192 and 65536 ticks.
- R2: The count advances by one on each cycle in which `tick` is high, but only while the enable bit is 1. While the enable bit is 0, ticks have no effect.
- R3: A read or a write at the keep-alive address `KEEP_ADDR` (default 0x60D) clears the count. If a tick arrives in the same cycle, the clear wins over the tick.
- R4: The tick that brings the count up to the selected limit asserts `resetReq` from the clock edge that samples that tick. The count then starts again from zero.
- R5: When `HOLD_RESET` = 0, `resetReq` is high for exactly one cycle per expiry.
- R6: When `HOLD_RESET` = 1, `resetReq` stays high once it has been asserted, until `rst` is applied.
- R7: The configuration register sits at `CFG_ADDR` (default 0x60C). In a write, bit 0 is the enable bit and bits [3:1] are the select code. Every configuration write also clears the count, so a change of select code always starts a full new interval.
- R8: A read at `CFG_ADDR` returns the enable bit in bit 0 and the select code in bits [3:1], with zeros above, in the same cycle as `busRdEn`. Reads at any other address return zero.
- R9: `rst` clears the enable bit, the select code, the count and `resetReq`. Writes at addresses other than `CFG_ADDR` and `KEEP_ADDR` change neither the configuration nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Prescaled time-base pulse, one cycle wide |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, valid in the cycle of `busRdEn` |
| resetReq | output | 1 | Board reset request |

## Verification
The bench sweeps all eight select codes, each after a fresh reset. For each code it gives one tick fewer than the limit and then the final tick, so an off-by-one or a wrong table entry shows up as an early or a missing expiry. A pulse-mode instance and a hold-mode instance run side by side on the same stimulus, which separates R5 from R6.

Keep-alive accesses are given as a read, as a write, and in the same cycle as a tick. This shows that a refresh restarts a full interval and that it wins over a tick arriving with it. Further patterns apply ticks while the watchdog is disabled, change the select code late in an interval, write to neighbouring addresses, and reset the block in the middle of an interval. Each of these must leave the count or the configuration exactly where the requirements say.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W      = 3;
  localparam int NUM_LIMITS = 1 << SEL_W;

  // Strobes from the register control to the counting datapath
  typedef struct packed {
    logic             clear;  // restart the count this cycle
    logic             run;    // enable bit
    logic [SEL_W-1:0] sel;    // timeout select code
  } wdgCmd_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 8,
  parameter int unsigned CFG_ADDR  = 32'h60C,
  parameter int unsigned KEEP_ADDR = 32'h60D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output wdgCmd_t           cmd
);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] KEEP_A = ADDR_W'(KEEP_ADDR);
  localparam int STATUS_W = SEL_W + 1;

  logic             enReg;
  logic [SEL_W-1:0] selReg;
  logic             cfgHit;
  logic             cfgWr;
  logic             keepAccess;

  assign cfgHit     = (busAddr == CFG_A);
  assign cfgWr      = busWrEn && cfgHit;
  assign keepAccess = (busWrEn || busRdEn) && (busAddr == KEEP_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg  <= 1'b0;
      selReg <= '0;
    end else if (cfgWr) begin
      enReg  <= busWrData[0];
      selReg <= busWrData[STATUS_W-1:1];
    end
  end

  assign busRdData = (busRdEn && cfgHit) ? DATA_W'({selReg, enReg}) : '0;

  always_comb begin
    cmd.clear = cfgWr || keepAccess;
    cmd.run   = enReg;
    cmd.sel   = selReg;
  end

  // R7: a configuration write loads enable and select
  p_cfg_load_r7: assert property (@(posedge clk) disable iff (rst)
    cfgWr |=> (cmd.run == $past(busWrData[0])) && (cmd.sel == $past(busWrData[STATUS_W-1:1])));

  // R9: writes elsewhere leave the configuration alone
  p_other_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && !cfgHit) |=> $stable({cmd.run, cmd.sel}));
endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int LIMIT_BASE = 2,
  parameter int TOP_EXP    = 15,
  parameter bit HOLD_RESET = 1'b0,
  parameter int CNT_W      = 17
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  wdgCmd_t cmd,
  output logic    resetReq
);
  logic [CNT_W-1:0] limitTab [NUM_LIMITS];
  logic [CNT_W-1:0] limitSel;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNext;
  logic             expireNow;

  for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_limit
    localparam int SH = (g * TOP_EXP) / (NUM_LIMITS - 1);
    assign limitTab[g] = CNT_W'(LIMIT_BASE) << SH;
  end

  assign limitSel  = limitTab[cmd.sel];
  assign countNext = count + CNT_W'(1);
  assign expireNow = !cmd.clear && cmd.run && tick && (countNext == limitSel);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (cmd.clear || expireNow) begin
      count <= '0;
    end else if (cmd.run && tick) begin
      count <= countNext;
    end
  end

  if (HOLD_RESET) begin : g_hold
    logic heldReq;
    always_ff @(posedge clk) begin
      if (rst) heldReq <= 1'b0;
      else     heldReq <= heldReq || expireNow;
    end
    assign resetReq = heldReq;

    // R6: once raised, the request stays until reset
    p_req_held_r6: assert property (@(posedge clk) disable iff (rst)
      resetReq |=> resetReq);
  end else begin : g_pulse
    logic pulseReq;
    always_ff @(posedge clk) begin
      if (rst) pulseReq <= 1'b0;
      else     pulseReq <= expireNow;
    end
    assign resetReq = pulseReq;

    // R5: one cycle per expiry (every limit is at least two ticks)
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      resetReq |=> !resetReq);
  end

  // R4: the count never sits at or above the selected limit
  p_below_limit_r4: assert property (@(posedge clk) disable iff (rst)
    count < limitSel);

  // R3: a refresh or configuration write leaves a zero count
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.clear |=> count == '0);

  // R2: no movement while disabled
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!cmd.run && !cmd.clear) |=> $stable(count));

  // R4: a new request only comes from a running watchdog
  p_expire_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(resetReq) |-> $past(cmd.run));
endmodule

// File: rtl/watchdog_core.sv
module watchdog_core
  import wdg_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 8,
  parameter int unsigned CFG_ADDR   = 32'h60C,
  parameter int unsigned KEEP_ADDR  = 32'h60D,
  parameter int          LIMIT_BASE = 2,
  parameter int          TOP_EXP    = 15,
  parameter bit          HOLD_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              resetReq
);
  localparam int CNT_W = $clog2(LIMIT_BASE << TOP_EXP) + 1;

  wdgCmd_t cmd;

  wdg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_ADDR(CFG_ADDR), .KEEP_ADDR(KEEP_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .cmd(cmd)
  );

  wdg_datapath #(
    .LIMIT_BASE(LIMIT_BASE), .TOP_EXP(TOP_EXP),
    .HOLD_RESET(HOLD_RESET), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .tick(tick), .cmd(cmd), .resetReq(resetReq)
  );
endmodule

// File: tb/watchdog_core_tb.sv
`timescale 1ns/1ps
module watchdog_core_tb;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int CFG_A  = 'h60C;
  localparam int KEEP_A = 'h60D;
  localparam int BASE   = 2;
  localparam int TEXP   = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] rdPulse, rdHold;
  logic              reqPulse, reqHold;

  int checks = 0;
  int fails  = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  watchdog_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIMIT_BASE(BASE),
                  .TOP_EXP(TEXP), .HOLD_RESET(1'b0)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(rdPulse), .resetReq(reqPulse));

  watchdog_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIMIT_BASE(BASE),
                  .TOP_EXP(TEXP), .HOLD_RESET(1'b1)) u_dutHold (
    .clk(clk), .rst(rst), .tick(tick), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(rdHold), .resetReq(reqHold));

  always @(posedge clk) begin
    #1;
    if (reqPulse) pulseCnt++;
  end

  function automatic int limitOf(int s);
    return BASE << ((s * TEXP) / 7);
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic busWrite(int a, int d);
    @(negedge clk);
    busAddr = ADDR_W'(a); busWrData = DATA_W'(d); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0;
  endtask

  task automatic busRead(int a, output int dP, output int dH);
    @(negedge clk);
    busAddr = ADDR_W'(a); busRdEn = 1'b1;
    #1; dP = int'(rdPulse); dH = int'(rdHold);
    @(negedge clk);
    busRdEn = 1'b0; busAddr = '0;
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic cfg(int sel, int en);
    busWrite(CFG_A, (sel << 1) | en);
  endtask

  initial begin
    int dP, dH, base;
    doReset();
    // R9: reset state
    check("R9 reset resetReq pulse", int'(reqPulse), 0);
    check("R9 reset resetReq hold", int'(reqHold), 0);
    busRead(CFG_A, dP, dH);
    check("R9 reset status", dP, 0);

    // R1 R4 R5 R6: sweep of every select code
    for (int s = 0; s < 8; s++) begin
      doReset();
      cfg(s, 1);
      busRead(CFG_A, dP, dH);
      check("R8 status readback", dP, (s << 1) | 1);
      base = pulseCnt;
      tickN(limitOf(s) - 1);
      check("R1 no early expiry", pulseCnt - base, 0);
      check("R1 hold no early expiry", int'(reqHold), 0);
      tickN(1);
      check("R4 expiry at limit", int'(reqPulse), 1);
      check("R4 hold expiry at limit", int'(reqHold), 1);
      @(negedge clk);
      check("R5 pulse one cycle", int'(reqPulse), 0);
      check("R6 hold stays high", int'(reqHold), 1);
      check("R5 single pulse count", pulseCnt - base, 1);
      // count restarted: a full new interval is needed
      tickN(limitOf(s) - 1);
      check("R4 restart no early", pulseCnt - base, 1);
      tickN(1);
      check("R4 second expiry", pulseCnt - base, 2);
      check("R6 hold still high", int'(reqHold), 1);
    end

    // R3: refresh by read, write, and same-cycle tick
    doReset();
    cfg(2, 1);
    base = pulseCnt;
    tickN(limitOf(2) - 1);
    busRead(KEEP_A, dP, dH);
    check("R8 keep-alive reads zero", dP, 0);
    tickN(limitOf(2) - 1);
    check("R3 read refresh", pulseCnt - base, 0);
    busWrite(KEEP_A, 8'hFF);
    tickN(limitOf(2) - 1);
    check("R3 write refresh", pulseCnt - base, 0);
    @(negedge clk);
    tick = 1'b1; busAddr = ADDR_W'(KEEP_A); busRdEn = 1'b1;
    @(negedge clk);
    tick = 1'b0; busRdEn = 1'b0; busAddr = '0;
    tickN(limitOf(2) - 1);
    check("R3 refresh beats tick", pulseCnt - base, 0);
    check("R3 hold untouched", int'(reqHold), 0);
    tickN(1);
    check("R3 expiry after refresh", pulseCnt - base, 1);

    // R2: disabled watchdog ignores ticks
    doReset();
    cfg(0, 0);
    base = pulseCnt;
    tickN(300);
    check("R2 disabled no expiry", pulseCnt - base, 0);
    check("R2 hold disabled", int'(reqHold), 0);
    busRead(CFG_A, dP, dH);
    check("R8 status disabled", dP, 0);

    // R7: select change late in an interval restarts the count
    doReset();
    cfg(3, 1);
    base = pulseCnt;
    tickN(limitOf(3) - 1);
    cfg(1, 1);
    tickN(limitOf(1) - 1);
    check("R7 change clears count", pulseCnt - base, 0);
    tickN(1);
    check("R7 new limit applies", pulseCnt - base, 1);

    // R9: other addresses have no effect
    doReset();
    cfg(2, 1);
    base = pulseCnt;
    tickN(limitOf(2) - 1);
    busWrite(KEEP_A + 1, 8'h00);
    busWrite(CFG_A - 1, 8'h0F);
    busRead(CFG_A - 1, dP, dH);
    check("R8 other address reads zero", dP, 0);
    busRead(CFG_A, dP, dH);
    check("R9 config unchanged", dP, (2 << 1) | 1);
    tickN(1);
    check("R9 no refresh from others", pulseCnt - base, 1);

    // R9: reset mid-interval
    cfg(4, 1);
    tickN(5);
    doReset();
    busRead(CFG_A, dP, dH);
    check("R9 reset clears config", dP, 0);
    check("R9 reset clears hold", int'(reqHold), 0);
    base = pulseCnt;
    tickN(limitOf(7) + 2);
    check("R9 no run after reset", pulseCnt - base, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule